// File: doc/BRIEF.md
# Counterflow Stage Transfer Controller

This block is the control state machine of one stage in a pipeline where instructions travel upward and results travel downward through the same chain of stages. Each stage can hold at most one instruction packet and one result packet. The controller tracks the stage's occupancy and decides, every cycle, whether to take an instruction from the stage below, take a result from the stage above, send its instruction upward and send its result downward. It looks only at its two neighbours' handshakes, so a chain of these stages forms an elastic pipeline whose packet count can vary.

The key obligation is that an instruction and a result travelling in opposite directions never cross a stage boundary in the same cycle. If they did, they would trade places without ever sharing a stage, and the comparison between them would be skipped. The controller breaks every such tie in favour of the result. When a stage holds both packets, it spends one cycle asserting a match strobe so the outside datapath can compare and execute. Only after that cycle may either packet leave. A hold input lets the datapath keep an unexecuted instruction in the last stage able to run it.

Top module: `cfx_stage_ctrl`

## Requirements
- R1: After reset the stage is empty: `stage_code` is 0 (codes: 0 empty, 1 instruction only, 2 result only, 3 both held awaiting match, 4 matched and ready to leave). In this state `ins_in_ready` and `res_in_ready` are 1, and `ins_up_valid`, `res_dn_valid` and `match_en` are 0.
- R2: In an empty stage, an incoming instruction alone gives code 1, an incoming result alone gives code 2, and both arriving in the same cycle give code 3.
- R3: With only an instruction held, no result offered from above and hold low, `ins_up_valid` is 1. When `ins_up_ready` is 1 the instruction leaves and the stage becomes empty. Otherwise the stage stays at code 1.
- R4: With only an instruction held, a result offered from above takes priority. `ins_up_valid` is 0, `res_in_ready` is 1, and the stage moves to code 3.
- R5: With only a result held, `res_dn_valid` is 1 and `ins_in_ready` equals the inverse of `res_dn_ready`. A result leaving empties the stage. Otherwise an offered instruction is taken and the stage moves to code 3.
- R6: At code 3, `match_en` is 1 for exactly one cycle. No ready or valid output is asserted, and the next state is code 4.
- R7: At code 4 no packet is accepted. The instruction and the result leave independently: both leaving gives code 0, only the instruction leaving gives code 2, only the result leaving gives code 1, and neither leaving keeps code 4.
- R8: While `must_hold` is 1, `ins_up_valid` is 0 and the instruction does not leave.
- R9: A packet moves to a neighbour only when that neighbour's ready is 1 in the same cycle. Otherwise the state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_in_valid | input | 1 | Stage below offers an instruction |
| ins_in_ready | output | 1 | This stage takes an instruction from below |
| ins_up_valid | output | 1 | This stage offers its instruction upward |
| ins_up_ready | input | 1 | Stage above has room for an instruction |
| res_in_valid | input | 1 | Stage above offers a result |
| res_in_ready | output | 1 | This stage takes a result from above |
| res_dn_valid | output | 1 | This stage offers its result downward |
| res_dn_ready | input | 1 | Stage below has room for a result |
| must_hold | input | 1 | Held instruction is unexecuted and this is its last capable stage |
| match_en | output | 1 | Strobe for the datapath to apply the matching rules |
| stage_code | output | 3 | Current occupancy code |

## Verification
All ready, valid and match outputs are combinational on the current state and inputs. They are sampled one time unit after inputs change, before the next rising edge. The occupancy code is registered and is due one edge after a handshake fires, so it is sampled just after that edge. The bench walks the stage into each of its five states and then applies all 32 combinations of the five control inputs. Each output and the following state are compared against values derived from the requirements.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  localparam int ST_W = 3;
  typedef enum logic [ST_W-1:0] {
    ST_EMPTY = 3'd0,
    ST_INS   = 3'd1,
    ST_RES   = 3'd2,
    ST_FULL  = 3'd3,
    ST_DONE  = 3'd4
  } stage_st_e;
endpackage

// File: rtl/cfx_port_decode.sv
module cfx_port_decode
  import cfx_pkg::*;
(
  input  stage_st_e st,
  input  logic      ins_in_valid,
  input  logic      res_in_valid,
  input  logic      ins_up_ready,
  input  logic      res_dn_ready,
  input  logic      must_hold,
  output logic      ins_in_ready,
  output logic      res_in_ready,
  output logic      ins_up_valid,
  output logic      res_dn_valid,
  output logic      match_en,
  output logic      ins_in_fire,
  output logic      res_in_fire,
  output logic      ins_up_fire,
  output logic      res_dn_fire
);
  always_comb begin
    res_in_ready = (st == ST_EMPTY) || (st == ST_INS);
    ins_in_ready = (st == ST_EMPTY) || ((st == ST_RES) && !res_dn_ready);
    ins_up_valid = !must_hold && (((st == ST_INS) && !res_in_valid) || (st == ST_DONE));
    res_dn_valid = (st == ST_RES) || (st == ST_DONE);
    match_en     = (st == ST_FULL);
    ins_in_fire  = ins_in_valid && ins_in_ready;
    res_in_fire  = res_in_valid && res_in_ready;
    ins_up_fire  = ins_up_valid && ins_up_ready;
    res_dn_fire  = res_dn_valid && res_dn_ready;
  end
endmodule

// File: rtl/cfx_next_state.sv
module cfx_next_state
  import cfx_pkg::*;
(
  input  stage_st_e st,
  input  logic      ins_in_fire,
  input  logic      res_in_fire,
  input  logic      ins_up_fire,
  input  logic      res_dn_fire,
  output stage_st_e st_nxt
);
  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_EMPTY: begin
        if (ins_in_fire && res_in_fire) st_nxt = ST_FULL;
        else if (ins_in_fire)           st_nxt = ST_INS;
        else if (res_in_fire)           st_nxt = ST_RES;
      end
      ST_INS: begin
        if (res_in_fire)      st_nxt = ST_FULL;
        else if (ins_up_fire) st_nxt = ST_EMPTY;
      end
      ST_RES: begin
        if (res_dn_fire)      st_nxt = ST_EMPTY;
        else if (ins_in_fire) st_nxt = ST_FULL;
      end
      ST_FULL: st_nxt = ST_DONE;
      ST_DONE: begin
        if (ins_up_fire && res_dn_fire) st_nxt = ST_EMPTY;
        else if (ins_up_fire)           st_nxt = ST_RES;
        else if (res_dn_fire)           st_nxt = ST_INS;
      end
      default: st_nxt = ST_EMPTY;
    endcase
  end
endmodule

// File: rtl/cfx_state_reg.sv
module cfx_state_reg
  import cfx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  stage_st_e st_nxt,
  output stage_st_e st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= ST_EMPTY;
    else if (load_en) st <= st_nxt;
  end
endmodule

// File: rtl/cfx_stage_ctrl.sv
module cfx_stage_ctrl
  import cfx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_in_valid,
  output logic            ins_in_ready,
  output logic            ins_up_valid,
  input  logic            ins_up_ready,
  input  logic            res_in_valid,
  output logic            res_in_ready,
  output logic            res_dn_valid,
  input  logic            res_dn_ready,
  input  logic            must_hold,
  output logic            match_en,
  output logic [ST_W-1:0] stage_code
);
  stage_st_e st, st_nxt;
  logic ins_in_fire, res_in_fire, ins_up_fire, res_dn_fire;
  logic load_en;

  cfx_port_decode u_dec (
    .st(st), .ins_in_valid(ins_in_valid), .res_in_valid(res_in_valid),
    .ins_up_ready(ins_up_ready), .res_dn_ready(res_dn_ready), .must_hold(must_hold),
    .ins_in_ready(ins_in_ready), .res_in_ready(res_in_ready),
    .ins_up_valid(ins_up_valid), .res_dn_valid(res_dn_valid), .match_en(match_en),
    .ins_in_fire(ins_in_fire), .res_in_fire(res_in_fire),
    .ins_up_fire(ins_up_fire), .res_dn_fire(res_dn_fire)
  );

  cfx_next_state u_nxt (
    .st(st), .ins_in_fire(ins_in_fire), .res_in_fire(res_in_fire),
    .ins_up_fire(ins_up_fire), .res_dn_fire(res_dn_fire), .st_nxt(st_nxt)
  );

  assign load_en = (st_nxt != st);

  cfx_state_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .st_nxt(st_nxt), .st(st)
  );

  assign stage_code = st;

  AST_NO_SWAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n) !(ins_up_fire && res_in_fire)); // R4
  AST_NO_SWAP_LOWER: assert property (@(posedge clk) disable iff (!rst_n) !(res_dn_fire && ins_in_fire)); // R5
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) match_en |=> (!match_en && stage_code == 3'd4)); // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (must_hold && stage_code == 3'd1) |=> stage_code != 3'd0); // R8
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (stage_code == 3'd2 && !res_dn_ready && !ins_in_valid) |=> stage_code == 3'd2); // R9
endmodule

// File: tb/cfx_stage_ctrl_test.sv
module cfx_stage_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic ins_in_valid, ins_up_ready, res_in_valid, res_dn_ready, must_hold;
  logic ins_in_ready, ins_up_valid, res_in_ready, res_dn_valid, match_en;
  logic [2:0] stage_code;
  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  cfx_stage_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ins_in_valid(ins_in_valid), .ins_in_ready(ins_in_ready),
    .ins_up_valid(ins_up_valid), .ins_up_ready(ins_up_ready),
    .res_in_valid(res_in_valid), .res_in_ready(res_in_ready),
    .res_dn_valid(res_dn_valid), .res_dn_ready(res_dn_ready),
    .must_hold(must_hold), .match_en(match_en), .stage_code(stage_code)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    {ins_in_valid, res_in_valid, ins_up_ready, res_dn_ready, must_hold} = v;
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // Bring the stage into code s using only the block's inputs
  task automatic go_state(input int s);
    @(negedge clk);
    drive(5'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    case (s)
      1: begin drive(5'b10000); step(); end
      2: begin drive(5'b01000); step(); end
      3: begin drive(5'b11000); step(); end
      4: begin drive(5'b11000); step(); drive(5'b0); step(); end
      default: ;
    endcase
    @(negedge clk);
  endtask

  function automatic string tag_of(input int s, input bit h);
    string t;
    case (s)
      0: t = "R2";
      1: t = "R3/R4";
      2: t = "R5";
      3: t = "R6";
      default: t = "R7";
    endcase
    if (h && (s == 1 || s == 4)) t = {t, "/R8"};
    return {t, "/R9"};
  endfunction

  initial begin
    #2_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(5'b0);
    #23;
    // R1 reset state
    chk("R1", "stage_code", stage_code, 0);
    chk("R1", "ins_in_ready", ins_in_ready, 1);
    chk("R1", "res_in_ready", res_in_ready, 1);
    chk("R1", "ins_up_valid", ins_up_valid, 0);
    chk("R1", "res_dn_valid", res_dn_valid, 0);
    chk("R1", "match_en", match_en, 0);
    for (int s = 0; s < 5; s++) begin
      for (int v = 0; v < 32; v++) begin
        bit iv, rv, ur, dr, h;
        bit e_ir, e_rr, e_uv, e_dv, e_m, f_ii, f_ri, f_uo, f_do;
        int e_nx;
        string tg;
        go_state(s);
        chk("R1", "setup code", stage_code, s);
        {iv, rv, ur, dr, h} = 5'(v);
        tg = tag_of(s, h);
        e_rr = (s == 0) || (s == 1);
        e_ir = (s == 0) || (s == 2 && !dr);
        e_uv = !h && ((s == 1 && !rv) || s == 4);
        e_dv = (s == 2) || (s == 4);
        e_m  = (s == 3);
        f_ii = iv && e_ir; f_ri = rv && e_rr;
        f_uo = e_uv && ur; f_do = e_dv && dr;
        e_nx = s;
        case (s)
          0: e_nx = f_ii ? (f_ri ? 3 : 1) : (f_ri ? 2 : 0);
          1: e_nx = f_ri ? 3 : (f_uo ? 0 : 1);
          2: e_nx = f_do ? 0 : (f_ii ? 3 : 2);
          3: e_nx = 4;
          default: e_nx = (f_uo && f_do) ? 0 : (f_uo ? 2 : (f_do ? 1 : 4));
        endcase
        drive(5'(v));
        #1;
        chk(tg, $sformatf("ins_in_ready s=%0d v=%0d", s, v), ins_in_ready, e_ir);
        chk(tg, $sformatf("res_in_ready s=%0d v=%0d", s, v), res_in_ready, e_rr);
        chk(tg, $sformatf("ins_up_valid s=%0d v=%0d", s, v), ins_up_valid, e_uv);
        chk(tg, $sformatf("res_dn_valid s=%0d v=%0d", s, v), res_dn_valid, e_dv);
        chk(tg, $sformatf("match_en s=%0d v=%0d", s, v), match_en, e_m);
        step();
        chk(tg, $sformatf("next code s=%0d v=%0d", s, v), stage_code, e_nx);
      end
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule